// File: doc/BRIEF.md
# Instruction Cache Control and Monitor Registers

This block is the software-visible control plane of a small instruction cache. A simple word-addressed read/write bus sets a global enable, chooses between a direct-mapped and a four-way associative arrangement, and starts a full invalidation. During an invalidation the block steps through the cache's line-valid storage one set per cycle and forces the cache into bypass. When the walk completes, it raises a completion flag that software can clear.

Two saturating event counters record cache hits and misses reported by the datapath. Each counter has its own enable and its own hold-at-zero control. An error pulse from the datapath is latched into a sticky flag. The completion flag and the error flag each have an interrupt enable, and the two are combined onto one interrupt line. The tag arrays, data arrays and refill logic belong to the surrounding cache.

Top module: `icache_ctrl_regs`

## Requirements
- R1: After reset the control word reads 0x0000_0004 (enable off, four-way selected). Status, interrupt enables and both counters read 0, `way4_o` is 1 and `irq_o` is 0.
- R2: Registers sit at these byte offsets: control 0x00, status 0x04, interrupt enable 0x08, flag clear 0x0C, hit count 0x10, miss count 0x14. Any other offset reads 0, and `rdata_o` follows `addr_i` in the same cycle.
- R3: Control bit 1 is the invalidate command. Writing 1 there while idle makes status bit 0 (busy) read 1 from the next cycle. `inval_we_o` is then high for exactly NSETS cycles, with `inval_set_o` counting 0, 1, ..., NSETS-1. After that, busy and control bit 1 read 0, and status bit 1 (done) is set.
- R4: `bypass_o` is 1 whenever control bit 0 (enable) is 0, and on every cycle an invalidation is running, including the first.
- R5: Control bit 2 selects the way mode (1 = four-way, 0 = direct-mapped) and drives `way4_o`. A write to it is ignored while enable is 1 or an invalidation is running.
- R6: A write of the invalidate command while an invalidation runs does not restart or extend it.
- R7: Writing 1 to bit 1 or bit 2 of the flag-clear register clears the done or error flag. Writing 0 has no effect. A set event in the same cycle as a clear keeps the flag set.
- R8: A one-cycle `err_i` pulse sets status bit 2 (error).
- R9: `irq_o` is 1 when done is set with interrupt-enable bit 1 set, or when error is set with interrupt-enable bit 2 set. Otherwise it is 0.
- R10: The hit counter (HIT_W bits, default 32) adds one per `hit_i` cycle when control bit 16 and enable are 1 and no invalidation is running. It stays at all ones instead of wrapping.
- R11: The miss counter (MISS_W bits, default 16) behaves the same way for `miss_i`, gated by control bit 17.
- R12: While control bit 18 (hit) or bit 19 (miss) is 1, the matching counter reads 0 and does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1 together with req_i |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| hit_i | input | 1 | Cache hit event pulse |
| miss_i | input | 1 | Cache miss event pulse |
| err_i | input | 1 | Cache error event pulse |
| bypass_o | output | 1 | Cache must bypass its arrays |
| way4_o | output | 1 | 1 = four-way, 0 = direct-mapped |
| irq_o | output | 1 | Combined interrupt |
| inval_we_o | output | 1 | Clear the valid bits of set inval_set_o |
| inval_set_o | output | $clog2(NSETS) | Set index being invalidated |

## Verification
Checked on every cycle by assertions:
- The invalidation sequencer starts at set 0 and advances by one set per cycle.
- A repeated command during an invalidation does not restart the walk.
- Bypass follows a start.
- The way mode is frozen while the cache is enabled or busy.
- The counters never wrap, and they sit at zero while held.
- A set event wins over a clear on each flag.

Shown only by the bench scenarios:
- The register map and the reset values.
- That no hit is counted during an invalidation even with the enable bit on.
- The interrupt masking.
- The exact counter totals under random enables and random event streams.

// File: rtl/icc_pkg.sv
package icc_pkg;
  // word indices (byte offset / 4)
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_IEN  = 2;
  localparam int unsigned OFS_FCLR = 3;
  localparam int unsigned OFS_HCNT = 4;
  localparam int unsigned OFS_MCNT = 5;

  // control word bits
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_INV  = 1;
  localparam int unsigned CB_WAY  = 2;
  localparam int unsigned CB_HEN  = 16;
  localparam int unsigned CB_MEN  = 17;
  localparam int unsigned CB_HRST = CB_HEN + 2;
  localparam int unsigned CB_MRST = CB_MEN + 2;

  // status / irq-enable / clear bits
  localparam int unsigned SB_BUSY = 0;
  localparam int unsigned SB_DONE = 1;
  localparam int unsigned SB_ERR  = 2;

  localparam int unsigned NFLAGS = 2;  // flag 0 = done, flag 1 = error

  typedef struct packed {
    logic en;
    logic way;
    logic hen;
    logic men;
    logic hrst;
    logic mrst;
  } ctrl_t;
endpackage

// File: rtl/icc_inval_seq.sv
module icc_inval_seq #(
  parameter int unsigned NSETS = 64,
  localparam int unsigned SW = $clog2(NSETS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          we_o,
  output logic [SW-1:0] set_o
);
  localparam logic [SW-1:0] LAST = SW'(NSETS - 1);

  logic          busy_q;
  logic [SW-1:0] set_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      set_q  <= '0;
    end else if (busy_q) begin
      if (set_q == LAST) begin
        busy_q <= 1'b0;
        set_q  <= '0;
      end else begin
        set_q <= set_q + SW'(1);
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      set_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  assign we_o   = busy_q;
  assign set_o  = set_q;
  assign done_o = busy_q && (set_q == LAST);

  assert_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && set_q == '0));
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && set_q != LAST) |=> (busy_q && set_q == $past(set_q) + SW'(1)));
  assert_finish_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
  assert_no_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && set_q != LAST && start_i) |=> (set_q != '0));
endmodule

// File: rtl/icc_sat_cnt.sv
module icc_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (inc_i && cnt_q != CMAX)  cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // shared by both counters: R10 and R11
  assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CMAX && !clr_i) |=> (cnt_q == CMAX));
  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
  assert_held_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/icc_flag.sv
module icc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/icache_ctrl_regs.sv
module icache_ctrl_regs
  import icc_pkg::*;
#(
  parameter int unsigned NSETS  = 64,
  parameter int unsigned HIT_W  = 32,
  parameter int unsigned MISS_W = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  input  logic                     hit_i,
  input  logic                     miss_i,
  input  logic                     err_i,
  output logic                     bypass_o,
  output logic                     way4_o,
  output logic                     irq_o,
  output logic                     inval_we_o,
  output logic [$clog2(NSETS)-1:0] inval_set_o
);
  localparam int unsigned WW = ADDR_W - 2;

  ctrl_t             ctrl_q;
  logic [NFLAGS-1:0] ie_q;
  logic [NFLAGS-1:0] flag_set, flag_clr, flag_q;
  logic [WW-1:0]     word;
  logic              wr_ctrl, wr_ien, wr_fclr;
  logic              busy, done, start;
  logic [HIT_W-1:0]  hcnt;
  logic [MISS_W-1:0] mcnt;

  assign word    = addr_i[ADDR_W-1:2];
  assign wr_ctrl = req_i && we_i && (word == WW'(OFS_CTRL));
  assign wr_ien  = req_i && we_i && (word == WW'(OFS_IEN));
  assign wr_fclr = req_i && we_i && (word == WW'(OFS_FCLR));
  assign start   = wr_ctrl && wdata_i[CB_INV];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{en: 1'b0, way: 1'b1, hen: 1'b0, men: 1'b0, hrst: 1'b0, mrst: 1'b0};
      ie_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en   <= wdata_i[CB_EN];
        ctrl_q.hen  <= wdata_i[CB_HEN];
        ctrl_q.men  <= wdata_i[CB_MEN];
        ctrl_q.hrst <= wdata_i[CB_HRST];
        ctrl_q.mrst <= wdata_i[CB_MRST];
        if (!ctrl_q.en && !busy) ctrl_q.way <= wdata_i[CB_WAY];
      end
      if (wr_ien) ie_q <= {wdata_i[SB_ERR], wdata_i[SB_DONE]};
    end
  end

  icc_inval_seq #(.NSETS(NSETS)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done),
    .we_o    (inval_we_o),
    .set_o   (inval_set_o)
  );

  assign flag_set = {err_i, done};
  assign flag_clr = {wr_fclr && wdata_i[SB_ERR], wr_fclr && wdata_i[SB_DONE]};

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    icc_flag i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .flag_o (flag_q[g])
    );
  end

  icc_sat_cnt #(.W(HIT_W)) i_hit_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_q.hrst),
    .inc_i  (hit_i && ctrl_q.hen && ctrl_q.en && !busy),
    .cnt_o  (hcnt)
  );

  icc_sat_cnt #(.W(MISS_W)) i_miss_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_q.mrst),
    .inc_i  (miss_i && ctrl_q.men && ctrl_q.en && !busy),
    .cnt_o  (mcnt)
  );

  always_comb begin
    rdata_o = '0;
    case (word)
      WW'(OFS_CTRL): begin
        rdata_o[CB_EN]   = ctrl_q.en;
        rdata_o[CB_INV]  = busy;
        rdata_o[CB_WAY]  = ctrl_q.way;
        rdata_o[CB_HEN]  = ctrl_q.hen;
        rdata_o[CB_MEN]  = ctrl_q.men;
        rdata_o[CB_HRST] = ctrl_q.hrst;
        rdata_o[CB_MRST] = ctrl_q.mrst;
      end
      WW'(OFS_STAT): begin
        rdata_o[SB_BUSY] = busy;
        rdata_o[SB_DONE] = flag_q[0];
        rdata_o[SB_ERR]  = flag_q[1];
      end
      WW'(OFS_IEN): begin
        rdata_o[SB_DONE] = ie_q[0];
        rdata_o[SB_ERR]  = ie_q[1];
      end
      WW'(OFS_HCNT): rdata_o[HIT_W-1:0]  = hcnt;
      WW'(OFS_MCNT): rdata_o[MISS_W-1:0] = mcnt;
      default: ;
    endcase
  end

  assign bypass_o = !ctrl_q.en || busy;
  assign way4_o   = ctrl_q.way;
  assign irq_o    = |(flag_q & ie_q);

  assert_bypass_on_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !busy) |=> bypass_o);
  assert_way_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en || busy) |=> $stable(way4_o));
  assert_err_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> (flag_q[1] && (irq_o || !ie_q[1])));
endmodule

// File: tb/test_icache_ctrl_regs.sv
module test_icache_ctrl_regs;
  localparam int unsigned NS = 8, HW = 6, MW = 4;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_IEN = 5'h08,
                         A_FCLR = 5'h0C, A_HCNT = 5'h10, A_MCNT = 5'h14;
  localparam logic [31:0] EN = 32'h1, INV = 32'h2, WAY = 32'h4,
                          HEN = 32'h1_0000, MEN = 32'h2_0000,
                          HRST = 32'h4_0000, MRST = 32'h8_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, hit = 1'b0, miss = 1'b0, err = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic bypass, way4, irq, iwe;
  logic [$clog2(NS)-1:0] iset;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  icache_ctrl_regs #(.NSETS(NS), .HIT_W(HW), .MISS_W(MW)) i_icache_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .hit_i(hit), .miss_i(miss), .err_i(err),
    .bypass_o(bypass), .way4_o(way4), .irq_o(irq), .inval_we_o(iwe),
    .inval_set_o(iset)
  );

  function automatic int unsigned sat_inc(int unsigned v, int unsigned vmax);
    return (v == vmax) ? v : v + 1;
  endfunction

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req_s, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned hexp, mexp, seed;
    logic ren, rhe, rme;
    seed = 32'd7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: reset values and map
    rd(A_CTRL, d); chk("R1 ctrl", d, WAY);
    rd(A_STAT, d); chk("R1 stat", d, 0);
    rd(A_IEN,  d); chk("R1 ien", d, 0);
    rd(A_HCNT, d); chk("R1 hcnt", d, 0);
    rd(A_MCNT, d); chk("R1 mcnt", d, 0);
    chk("R1 way4", way4, 1); chk("R1 irq", irq, 0); chk("R4 bypass off", bypass, 1);
    rd(5'h18, d); chk("R2 unmapped", d, 0);
    wr(A_IEN, 32'h6); rd(A_IEN, d); chk("R2 ien rw", d, 32'h6);
    wr(A_IEN, 0);

    // R3/R4/R10: invalidation with counting enabled, hits must be ignored
    wr(A_CTRL, EN | HEN | WAY | INV);
    hit = 1'b1;
    for (int i = 0; i < NS; i++) begin
      chk("R3 inval_we", iwe, 1); chk("R3 set index", iset, i);
      chk("R4 bypass busy", bypass, 1);
      if (i == 0) begin addr = A_STAT; #1 chk("R3 busy", rdata[0], 1); end
      @(negedge clk);
    end
    hit = 1'b0;
    chk("R3 inval_we end", iwe, 0); chk("R4 bypass end", bypass, 0);
    rd(A_HCNT, d); chk("R10 no count busy", d, 0);
    rd(A_STAT, d); chk("R3 done flag", d, 32'h2);
    rd(A_CTRL, d); chk("R3 inv self clear", d, EN | HEN | WAY);

    // R9 / R7: done interrupt and clear
    chk("R9 masked", irq, 0);
    wr(A_IEN, 32'h2); chk("R9 done irq", irq, 1);
    wr(A_FCLR, 32'h0); rd(A_STAT, d); chk("R7 write0", d, 32'h2);
    wr(A_FCLR, 32'h2); rd(A_STAT, d); chk("R7 clear done", d, 0);
    chk("R9 irq low", irq, 0);

    // R5/R6: second command and way write during invalidation
    wr(A_CTRL, WAY);
    wr(A_CTRL, WAY | INV);
    for (int i = 0; i < NS; i++) begin
      chk("R6 set index", iset, i); chk("R6 busy", iwe, 1);
      if (i == 3) begin req = 1'b1; we = 1'b1; addr = A_CTRL; wdata = INV; end
      @(negedge clk);
      if (i == 3) begin req = 1'b0; we = 1'b0; end
    end
    chk("R6 ends on time", iwe, 0);
    rd(A_CTRL, d); chk("R5 way kept busy", d, WAY);
    wr(A_CTRL, 0);       chk("R5 way idle write", way4, 0);
    wr(A_CTRL, EN);
    wr(A_CTRL, EN | WAY); chk("R5 way locked en", way4, 0);
    wr(A_CTRL, WAY);      chk("R5 way locked en2", way4, 0);
    wr(A_CTRL, WAY);      chk("R5 way set", way4, 1);
    wr(A_FCLR, 32'h6);

    // R8/R7/R9: error flag
    @(negedge clk); err = 1'b1; @(negedge clk); err = 1'b0;
    rd(A_STAT, d); chk("R8 err set", d, 32'h4);
    chk("R9 err masked", irq, 0);
    wr(A_IEN, 32'h4); chk("R9 err irq", irq, 1);
    @(negedge clk); err = 1'b1; req = 1'b1; we = 1'b1; addr = A_FCLR; wdata = 32'h4;
    @(negedge clk); err = 1'b0; req = 1'b0; we = 1'b0;
    rd(A_STAT, d); chk("R7 set wins", d, 32'h4);
    wr(A_IEN, 0); chk("R9 disabled", irq, 0);
    wr(A_FCLR, 32'h4); rd(A_STAT, d); chk("R7 clear err", d, 0);

    // R10/R11: saturation
    wr(A_CTRL, EN | HEN | MEN | WAY);
    hit = 1'b1; miss = 1'b1;
    repeat (70) @(negedge clk);
    hit = 1'b0; miss = 1'b0;
    rd(A_HCNT, d); chk("R10 saturate", d, (1 << HW) - 1);
    rd(A_MCNT, d); chk("R11 saturate", d, (1 << MW) - 1);

    // R12: held at zero
    wr(A_CTRL, EN | HEN | MEN | HRST | MRST | WAY);
    hit = 1'b1; miss = 1'b1;
    repeat (5) @(negedge clk);
    hit = 1'b0; miss = 1'b0;
    rd(A_HCNT, d); chk("R12 hit held", d, 0);
    rd(A_MCNT, d); chk("R12 miss held", d, 0);

    // random phase: R10 / R11 against model
    hexp = 0; mexp = 0;
    for (int r = 0; r < 25; r++) begin
      ren = 1'($urandom); rhe = 1'($urandom); rme = 1'($urandom);
      if ($urandom % 5 == 0) begin
        wr(A_CTRL, WAY | HRST | MRST); hexp = 0; mexp = 0;
      end
      wr(A_CTRL, WAY | (ren ? EN : 0) | (rhe ? HEN : 0) | (rme ? MEN : 0));
      for (int c = 0; c < 10 + int'($urandom % 30); c++) begin
        @(negedge clk);
        hit = 1'($urandom); miss = 1'($urandom);
        if (ren && rhe && hit)  hexp = sat_inc(hexp, (1 << HW) - 1);
        if (ren && rme && miss) mexp = sat_inc(mexp, (1 << MW) - 1);
      end
      @(negedge clk); hit = 1'b0; miss = 1'b0;
      rd(A_HCNT, d); chk("R10 random", d, hexp);
      rd(A_MCNT, d); chk("R11 random", d, mexp);
    end

    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end
endmodule